// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects three interrupt causes from a graphics engine and presents them to a host processor as a single active-high interrupt line. Two causes are one-cycle event pulses from the engine: the binning stage finishing a flush, and the render stage finishing a frame. Each pulse latches a pending bit. The third cause is the binner running out of overflow memory. It is level-driven: its pending bit keeps coming back while the shortage lasts, and the shortage lasts until software supplies a fresh overflow pool.

The host reaches the block through a simple synchronous register bus. A pending-status register is cleared by writing ones. The enable mask has two write ports: one sets bits, the other clears them. Both return the same mask when read, so software can change one source without a read-modify-write. A pair of registers holds the base and size of the overflow pool. Writing a new base and then a nonzero size ends the shortage.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset, the enable mask, pool base and pool size read as zero, and `irq_o` is low. The memory-shortage condition is active out of reset, so status bit 2 reads 1 from the first cycle after reset, while bits 1 and 0 read 0.
- R2: Word addresses are: 0 pending status, 1 enable-set, 2 enable-clear, 3 pool base, 4 pool size. Status and enable bits are: bit 0 frame done, bit 1 flush done, bit 2 memory shortage. Status and enable bits above bit 2 read as zero and cannot be written. Any other address reads as zero.
- R3: Writing to address 0 clears each status bit that the write data has set to 1. Bits written as 0 are left unchanged.
- R4: A pulse on `frame_done_i` or `flush_done_i` sets its status bit on that clock edge. If a clear hits the same bit in the same cycle, the bit stays set.
- R5: Writing to address 1 enables each source whose data bit is 1. Data bits of 0 leave the mask unchanged.
- R6: Writing to address 2 disables each source whose data bit is 1. Data bits of 0 leave the mask unchanged.
- R7: Reading either address 1 or address 2 returns the current enable mask.
- R8: `irq_o` is registered. It equals the OR of (status AND enable) as that value stood one clock earlier.
- R9: While the memory-shortage condition is active, status bit 2 is set again on every cycle, so a write-1 clear of that bit has no visible effect.
- R10: The shortage condition starts, or continues, on any cycle with `pool_exhausted_i` high. It ends only when the pool size is written with a nonzero value after the pool base has been written since the condition began. Writing a size of zero, or writing a size without a fresh base, does not end it. Once it has ended, bit 2 can be cleared.
- R11: `rd_data_o` carries the addressed register one cycle after `rd_en_i`, and reads zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Registered read data |
| frame_done_i | input | 1 | Render frame done event pulse |
| flush_done_i | input | 1 | Binning flush done event pulse |
| pool_exhausted_i | input | 1 | Engine reports that the overflow pool is used up |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
Each result appears a fixed number of cycles after its stimulus:
- A write or an event changes status, the enable mask or the shortage condition on the edge that samples it.
- `irq_o` follows that change one edge later.
- Read data lands on the edge after `rd_en_i`.

The reference model in the bench applies the same edge ordering: old state in, new state out on each rising edge. The outputs are compared against the model at every falling edge, midway between edges. Directed reads sample `rd_data_o` at the falling edge after the read strobe, and they place the pending-bit and shortage corners at exact cycles. These corners include an event colliding with a clear, a size written without a fresh base, and a clear issued while the shortage is active.

// File: rtl/gic_pkg.sv
package gic_pkg;

    localparam int NSRC    = 3;
    localparam int REG_AW  = 3;
    localparam int B_FRAME = 0;
    localparam int B_FLUSH = 1;
    localparam int B_OOM   = 2;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [REG_AW-1:0] {
        RA_STATUS    = 3'd0,
        RA_EN_SET    = 3'd1,
        RA_EN_CLR    = 3'd2,
        RA_POOL_BASE = 3'd3,
        RA_POOL_SIZE = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic status_w;
        logic en_set_w;
        logic en_clr_w;
        logic base_w;
        logic size_w;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic we, input logic [REG_AW-1:0] a);
        wr_dec_t d;
        d.status_w = we && (a == RA_STATUS);
        d.en_set_w = we && (a == RA_EN_SET);
        d.en_clr_w = we && (a == RA_EN_CLR);
        d.base_w   = we && (a == RA_POOL_BASE);
        d.size_w   = we && (a == RA_POOL_SIZE);
        return d;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import gic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t status_o
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) status_o[i] <= 1'b0;
            else     status_o[i] <= set_i[i] | (status_o[i] & ~clr_i[i]);
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i))); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((status_o & $past(clr_i & ~set_i)) == '0)); // R3

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import gic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t enable_o
);

    always_ff @(posedge clk) begin
        if (rst) enable_o <= '0;
        else     enable_o <= (enable_o | set_i) & ~clr_i;
    end

    AST_SET_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((enable_o & $past(set_i)) == $past(set_i))); // R5

    AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (rst)
        (|clr_i) |=> ((enable_o & $past(clr_i)) == '0)); // R6

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(enable_o)); // R5

endmodule

// File: rtl/pool_tracker.sv
module pool_tracker #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exhausted_i,
    input  logic              base_we_i,
    input  logic              size_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              cond_o,
    output logic [DATA_W-1:0] base_o,
    output logic [DATA_W-1:0] size_o
);

    logic base_fresh;
    logic refill;

    assign refill = size_we_i && (wdata_i != '0) && base_fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_o     <= 1'b1;
            base_fresh <= 1'b0;
            base_o     <= '0;
            size_o     <= '0;
        end else begin
            cond_o <= exhausted_i | (cond_o & ~refill);
            if (exhausted_i)    base_fresh <= 1'b0;
            else if (refill)    base_fresh <= 1'b0;
            else if (base_we_i) base_fresh <= 1'b1;
            if (base_we_i) base_o <= wdata_i;
            if (size_we_i) size_o <= wdata_i;
        end
    end

    AST_ZERO_SIZE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cond_o && size_we_i && wdata_i == '0) |=> cond_o); // R10

    AST_EXHAUST_SETS: assert property (@(posedge clk) disable iff (rst)
        exhausted_i |=> cond_o); // R10

endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
    import gic_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              frame_done_i,
    input  logic              flush_done_i,
    input  logic              pool_exhausted_i,
    output logic              irq_o
);

    wr_dec_t           dec;
    src_vec_t          wsrc;
    src_vec_t          st_set, st_clr, en_set, en_clr;
    src_vec_t          status, enable;
    logic              oom_cond;
    logic [DATA_W-1:0] pool_base, pool_size;
    logic [DATA_W-1:0] rd_next;

    assign dec  = decode_write(wr_en_i, addr_i);
    assign wsrc = wr_data_i[NSRC-1:0];

    always_comb begin
        st_set          = '0;
        st_set[B_FRAME] = frame_done_i;
        st_set[B_FLUSH] = flush_done_i;
        st_set[B_OOM]   = oom_cond;
    end

    assign st_clr = dec.status_w ? wsrc : '0;
    assign en_set = dec.en_set_w ? wsrc : '0;
    assign en_clr = dec.en_clr_w ? wsrc : '0;

    irq_status_bank u_status (
        .clk      (clk),
        .rst      (rst),
        .set_i    (st_set),
        .clr_i    (st_clr),
        .status_o (status)
    );

    irq_enable_bank u_enable (
        .clk      (clk),
        .rst      (rst),
        .set_i    (en_set),
        .clr_i    (en_clr),
        .enable_o (enable)
    );

    pool_tracker #(.DATA_W(DATA_W)) u_pool (
        .clk         (clk),
        .rst         (rst),
        .exhausted_i (pool_exhausted_i),
        .base_we_i   (dec.base_w),
        .size_we_i   (dec.size_w),
        .wdata_i     (wr_data_i),
        .cond_o      (oom_cond),
        .base_o      (pool_base),
        .size_o      (pool_size)
    );

    always_comb begin
        rd_next = '0;
        case (addr_i)
            RA_STATUS:              rd_next = DATA_W'(status);
            RA_EN_SET, RA_EN_CLR:   rd_next = DATA_W'(enable);
            RA_POOL_BASE:           rd_next = pool_base;
            RA_POOL_SIZE:           rd_next = pool_size;
            default:                rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o <= '0;
            irq_o     <= 1'b0;
        end else begin
            rd_data_o <= rd_en_i ? rd_next : '0;
            irq_o     <= |(status & enable);
        end
    end

    AST_OOM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        oom_cond |=> status[B_OOM]); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((status & enable) == '0) |=> !irq_o); // R8

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> (rd_data_o == '0)); // R11

endmodule

// File: tb/test_gfx_irq_ctrl.sv
module test_gfx_irq_ctrl;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wd = '0;
    logic          re = 1'b0;
    logic [DW-1:0] rd_data;
    logic          frame = 1'b0;
    logic          flush = 1'b0;
    logic          exh = 1'b0;
    logic          irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    gfx_irq_ctrl #(.DATA_W(DW)) i_gfx_irq_ctrl (
        .clk              (clk),
        .rst              (rst),
        .addr_i           (addr),
        .wr_en_i          (we),
        .wr_data_i        (wd),
        .rd_en_i          (re),
        .rd_data_o        (rd_data),
        .frame_done_i     (frame),
        .flush_done_i     (flush),
        .pool_exhausted_i (exh),
        .irq_o            (irq)
    );

    // behavioural reference model
    int unsigned   m_status, m_en, m_base, m_size, m_rd;
    bit            m_cond, m_fresh, m_irq;

    function automatic int unsigned m_read(input int a);
        case (a)
            0:       return m_status;
            1, 2:    return m_en;
            3:       return m_base;
            4:       return m_size;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int unsigned n_status, n_en, n_rd, clr;
        bit n_cond, n_fresh, n_irq, refill;
        if (rst) begin
            m_status = 0; m_en = 0; m_base = 0; m_size = 0; m_rd = 0;
            m_cond = 1; m_fresh = 0; m_irq = 0;
        end else begin
            clr      = (we && addr == 0) ? (wd & 32'h7) : 0;
            n_status = (m_status & ~clr) | (m_cond ? 4 : 0) | (flush ? 2 : 0) | (frame ? 1 : 0);
            n_en     = m_en;
            if (we && addr == 1) n_en = n_en | (wd & 32'h7);
            if (we && addr == 2) n_en = n_en & ~(wd & 32'h7);
            n_irq    = (m_status & m_en) != 0;
            n_rd     = re ? m_read(addr) : 0;
            refill   = we && addr == 4 && wd != 0 && m_fresh;
            n_cond   = exh || (m_cond && !refill);
            n_fresh  = m_fresh;
            if (exh) n_fresh = 0;
            else if (refill) n_fresh = 0;
            else if (we && addr == 3) n_fresh = 1;
            if (we && addr == 3) m_base = wd;
            if (we && addr == 4) m_size = wd;
            m_status = n_status; m_en = n_en; m_irq = n_irq; m_rd = n_rd;
            m_cond = n_cond; m_fresh = n_fresh;
        end
    end

    // per-cycle comparison, midway between edges
    always @(negedge clk) begin
        if (!rst) begin
            total++;
            if (irq !== m_irq) begin
                bad++;
                $display("FAIL R8 irq_o actual=%0b expected=%0b", irq, m_irq);
            end
            total++;
            if (rd_data !== m_rd) begin
                bad++;
                $display("FAIL R11 rd_data actual=%0h expected=%0h", rd_data, m_rd);
            end
        end
    end

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int unsigned d);
        @(negedge clk);
        addr = a[2:0]; wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wd = '0;
    endtask

    task automatic rd(input int a, input int unsigned exp, input string tag);
        @(negedge clk);
        addr = a[2:0]; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        check(tag, rd_data, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);
        // R1 reset state
        check("R1 irq after reset", irq, 0);
        rd(0, 32'h4, "R1 status after reset");
        rd(1, 0, "R1 enable after reset");
        rd(3, 0, "R1 pool base after reset");
        rd(4, 0, "R1 pool size after reset");
        // R5 / R7 enable all
        wr(1, 32'h7);
        rd(1, 32'h7, "R5 enable-set");
        rd(2, 32'h7, "R7 enable via clear address");
        check("R8 irq with shortage enabled", irq, 1);
        // R9 clear of bit 2 while active
        wr(0, 32'h4);
        rd(0, 32'h4, "R9 shortage bit reasserts");
        // R6 disable shortage, zero write ignored
        wr(2, 32'h4);
        wr(2, 32'h0);
        rd(2, 32'h3, "R6 enable-clear");
        wr(1, 32'h0);
        rd(1, 32'h3, "R5 zero write ignored");
        idle(1);
        check("R8 irq low when masked", irq, 0);
        // R4 frame event, R3 clear
        @(negedge clk); frame = 1'b1;
        @(negedge clk); frame = 1'b0;
        rd(0, 32'h5, "R4 frame event latched");
        check("R8 irq on frame", irq, 1);
        wr(0, 32'h0);
        rd(0, 32'h5, "R3 zero write keeps status");
        wr(0, 32'h1);
        rd(0, 32'h4, "R3 write-1 clears frame bit");
        // R4 event collides with clear
        @(negedge clk); flush = 1'b1; addr = 3'd0; wd = 32'h2; we = 1'b1;
        @(negedge clk); flush = 1'b0; we = 1'b0; wd = '0;
        rd(0, 32'h6, "R4 event wins over clear");
        wr(0, 32'h2);
        rd(0, 32'h4, "R3 flush bit cleared");
        // R2 upper bits and unused address
        wr(1, 32'hFFFF_FFF8);
        rd(1, 32'h3, "R2 upper enable bits ignored");
        rd(5, 0, "R2 unmapped address");
        rd(7, 0, "R2 unmapped address 7");
        // R10 pool refill sequencing
        wr(4, 32'h100);
        wr(0, 32'h4);
        rd(0, 32'h4, "R10 size without base keeps shortage");
        wr(3, 32'h8000);
        wr(4, 32'h0);
        wr(0, 32'h4);
        rd(0, 32'h4, "R10 zero size keeps shortage");
        wr(4, 32'h4_0000);
        wr(0, 32'h4);
        rd(0, 32'h0, "R10 refill ends shortage");
        rd(3, 32'h8000, "R10 pool base readback");
        rd(4, 32'h4_0000, "R10 pool size readback");
        // R10 shortage returns
        @(negedge clk); exh = 1'b1;
        @(negedge clk); exh = 1'b0;
        wr(0, 32'h4);
        rd(0, 32'h4, "R10 exhaustion restarts shortage");
        wr(1, 32'h4);
        idle(2);
        check("R8 irq for shortage", irq, 1);
        idle(2);
        check("R11 idle read data", rd_data, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule